// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencer

This block is the control unit of a small 16-bit processor that takes several clock cycles for each instruction. It reads the 4-bit opcode and the 3-bit function field held in the instruction register. It walks through ten numbered states and drives the write strobes and multiplexer selects of a separate datapath, which holds the program counter, the operand and result registers, the ALU and the memories.

Every instruction starts with a fetch state and a decode state. After decode the sequence takes one of three paths: register-register ALU work, a memory address computation for loads and stores, or an OR with an immediate. Each path ends in its own finish state. The finish state moves the next-PC value into the PC and returns to fetch. All strobes come straight from flip-flops, so the datapath sees clean enables. The present state code is brought out so the sequence can be observed.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state code becomes 0 (fetch). In fetch, `ir_we` and `npc_we` are 1 and every other strobe and `alu_op` are 0.
- R2: Fetch (0) always moves to decode (1). In decode every strobe is 0 and `alu_op` is 0000.
- R3: From decode, opcode 0000 moves to state 2, opcodes 0001 and 0010 move to state 4, and opcode 0100 moves to state 8. Any other opcode moves back to state 0. The state code never leaves the range 0 to 9.
- R4: State 2 asserts `aluout_we` with `b_from_imm`=0. Its `alu_op` is 0100 (add) for func 001, 0010 (AND) for func 011, and 0000 for any other func. State 2 moves to state 3. State 3 asserts `rf_we`, `dst_from_rd`=1 and `pc_we`, with `wb_from_mem`=0.
- R5: State 4 asserts `imm_signed`, `b_from_imm` and `aluout_we`, with `alu_op`=0100. It moves to state 5 for opcode 0001, to state 7 for opcode 0010, and to state 0 otherwise.
- R6: State 5 asserts only `lmd_we` and moves to state 6. State 6 asserts `rf_we`, `wb_from_mem` and `pc_we`, with `dst_from_rd`=0.
- R7: State 7 asserts `mem_we` and `pc_we`, and `rf_we` stays 0. Memory write happens only in state 7, which is entered only from state 4.
- R8: State 8 asserts `b_from_imm` and `aluout_we` with `imm_signed`=0 and `alu_op`=0001 (OR), and moves to state 9. State 9 asserts `rf_we` and `pc_we`, with `dst_from_rd`=0 and `wb_from_mem`=0.
- R9: States 3, 6, 7 and 9 move to state 0 on the next edge. `pc_we` is asserted in no other state.
- R10: Any strobe not named for a state above is 0 in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to fetch |
| opcode | input | 4 | Opcode field of the instruction register |
| func | input | 3 | Function field of the instruction register |
| pc_we | output | 1 | Load the PC from the next-PC register |
| npc_we | output | 1 | Load the next-PC register with PC+1 |
| ir_we | output | 1 | Load the instruction register |
| rf_we | output | 1 | Register file write |
| aluout_we | output | 1 | Load the ALU result register |
| mem_we | output | 1 | Data memory write |
| lmd_we | output | 1 | Load the memory data register |
| dst_from_rd | output | 1 | Destination register index: 1 takes rd, 0 takes rt |
| b_from_imm | output | 1 | ALU operand B: 1 takes the extended immediate, 0 takes register B |
| wb_from_mem | output | 1 | Write-back data: 1 takes the memory data register, 0 takes the ALU result |
| imm_signed | output | 1 | Immediate extension: 1 sign-extends, 0 zero-extends |
| alu_op | output | 4 | ALU function code |
| state_code | output | 4 | Present state number |

## Verification
A wrong state register shows at the ports on the very next edge. The state code and the whole strobe pattern both come from the same update, so a mis-routed opcode gives an unexpected state number one cycle after decode. A wrong strobe in any state also appears in that same cycle. A path that fails to close shows up as a missing return to state 0 and a missing `pc_we` at the point where the instruction should end. Each instruction is therefore compared as a cycle-by-cycle pattern, from decode until the sequence is back in fetch.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OP_W = 4;
  localparam int FN_W = 3;
  localparam int ST_W = 4;
  localparam int AF_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_REXEC  = 4'd2,
    S_RFIN   = 4'd3,
    S_MADDR  = 4'd4,
    S_MREAD  = 4'd5,
    S_LFIN   = 4'd6,
    S_SFIN   = 4'd7,
    S_OEXEC  = 4'd8,
    S_IFIN   = 4'd9
  } state_t;

  localparam logic [OP_W-1:0] OPC_RTYPE = 4'b0000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0001;
  localparam logic [OP_W-1:0] OPC_STORE = 4'b0010;
  localparam logic [OP_W-1:0] OPC_ORI   = 4'b0100;

  localparam logic [FN_W-1:0] FN_ADD = 3'b001;
  localparam logic [FN_W-1:0] FN_AND = 3'b011;

  localparam logic [AF_W-1:0] ALU_PASS = 4'b0000;
  localparam logic [AF_W-1:0] ALU_OR   = 4'b0001;
  localparam logic [AF_W-1:0] ALU_AND  = 4'b0010;
  localparam logic [AF_W-1:0] ALU_ADD  = 4'b0100;

  typedef struct packed {
    logic            pc_we;
    logic            npc_we;
    logic            ir_we;
    logic            rf_we;
    logic            aluout_we;
    logic            mem_we;
    logic            lmd_we;
    logic            dst_rd;
    logic            b_imm;
    logic            wb_mem;
    logic            imm_sext;
    logic [AF_W-1:0] alu;
  } strobe_t;
endpackage

// File: rtl/mcc_next.sv
module mcc_next
  import mcc_pkg::*;
(
  input  state_t          cur,
  input  logic [OP_W-1:0] opcode,
  output state_t          nxt
);
  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if (opcode == OPC_RTYPE)                            nxt = S_REXEC;
        else if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = S_MADDR;
        else if (opcode == OPC_ORI)                         nxt = S_OEXEC;
        else                                                nxt = S_FETCH;
      end
      S_REXEC:  nxt = S_RFIN;
      S_MADDR: begin
        if (opcode == OPC_LOAD)       nxt = S_MREAD;
        else if (opcode == OPC_STORE) nxt = S_SFIN;
        else                          nxt = S_FETCH;
      end
      S_MREAD:  nxt = S_LFIN;
      S_OEXEC:  nxt = S_IFIN;
      S_RFIN, S_LFIN, S_SFIN, S_IFIN: nxt = S_FETCH;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_strobe.sv
module mcc_strobe
  import mcc_pkg::*;
(
  input  state_t          st,
  input  logic [FN_W-1:0] func,
  output strobe_t         sb
);
  logic [AF_W-1:0] rfunc;

  always_comb begin
    unique case (func)
      FN_ADD:  rfunc = ALU_ADD;
      FN_AND:  rfunc = ALU_AND;
      default: rfunc = ALU_PASS;
    endcase
  end

  always_comb begin
    sb = '0;
    unique case (st)
      S_FETCH: begin
        sb.ir_we  = 1'b1;
        sb.npc_we = 1'b1;
      end
      S_REXEC: begin
        sb.aluout_we = 1'b1;
        sb.alu       = rfunc;
      end
      S_RFIN: begin
        sb.rf_we  = 1'b1;
        sb.dst_rd = 1'b1;
        sb.pc_we  = 1'b1;
      end
      S_MADDR: begin
        sb.imm_sext  = 1'b1;
        sb.b_imm     = 1'b1;
        sb.alu       = ALU_ADD;
        sb.aluout_we = 1'b1;
      end
      S_MREAD: sb.lmd_we = 1'b1;
      S_LFIN: begin
        sb.rf_we  = 1'b1;
        sb.wb_mem = 1'b1;
        sb.pc_we  = 1'b1;
      end
      S_SFIN: begin
        sb.mem_we = 1'b1;
        sb.pc_we  = 1'b1;
      end
      S_OEXEC: begin
        sb.b_imm     = 1'b1;
        sb.alu       = ALU_OR;
        sb.aluout_we = 1'b1;
      end
      S_IFIN: begin
        sb.rf_we = 1'b1;
        sb.pc_we = 1'b1;
      end
      default: sb = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] func,
  output logic            pc_we,
  output logic            npc_we,
  output logic            ir_we,
  output logic            rf_we,
  output logic            aluout_we,
  output logic            mem_we,
  output logic            lmd_we,
  output logic            dst_from_rd,
  output logic            b_from_imm,
  output logic            wb_from_mem,
  output logic            imm_signed,
  output logic [AF_W-1:0] alu_op,
  output logic [ST_W-1:0] state_code
);
  state_t  state_q, state_n, dec_in;
  strobe_t sb_n, sb_q;

  mcc_next u_next (.cur(state_q), .opcode(opcode), .nxt(state_n));

  assign dec_in = rst ? S_FETCH : state_n;

  mcc_strobe u_strobe (.st(dec_in), .func(func), .sb(sb_n));

  always_ff @(posedge clk) begin
    state_q <= dec_in;
    sb_q    <= sb_n;
  end

  assign state_code  = state_q;
  assign pc_we       = sb_q.pc_we;
  assign npc_we      = sb_q.npc_we;
  assign ir_we       = sb_q.ir_we;
  assign rf_we       = sb_q.rf_we;
  assign aluout_we   = sb_q.aluout_we;
  assign mem_we      = sb_q.mem_we;
  assign lmd_we      = sb_q.lmd_we;
  assign dst_from_rd = sb_q.dst_rd;
  assign b_from_imm  = sb_q.b_imm;
  assign wb_from_mem = sb_q.wb_mem;
  assign imm_signed  = sb_q.imm_sext;
  assign alu_op      = sb_q.alu;

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'd0 |=> state_code == 4'd1);                                   // R2
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    state_code <= 4'd9);                                                          // R3
  AST_IMM_WRITES_RESULT: assert property (@(posedge clk) disable iff (rst)
    b_from_imm |-> aluout_we);                                                    // R5
  AST_LMD_BEFORE_LOAD_WB: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'd6 |-> $past(lmd_we));                                        // R6
  AST_STORE_FROM_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state_code == 4'd7 && $past(state_code) == 4'd4));                // R7
  AST_FINISH_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd3 || state_code == 4'd6 || state_code == 4'd7 || state_code == 4'd9)
    |=> state_code == 4'd0);                                                      // R9
  AST_PC_ONLY_IN_FINISH: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> (state_code == 4'd3 || state_code == 4'd6 || state_code == 4'd7 || state_code == 4'd9)); // R9
  AST_SINGLE_STORAGE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ir_we, rf_we, mem_we, lmd_we}));                                    // R10
endmodule

// File: tb/sim_mcyc_ctrl.sv
module sim_mcyc_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] opcode = 4'd0;
  logic [2:0] func = 3'd0;
  logic pc_we, npc_we, ir_we, rf_we, aluout_we, mem_we, lmd_we;
  logic dst_from_rd, b_from_imm, wb_from_mem, imm_signed;
  logic [3:0] alu_op, state_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  mcyc_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .func(func),
    .pc_we(pc_we), .npc_we(npc_we), .ir_we(ir_we), .rf_we(rf_we),
    .aluout_we(aluout_we), .mem_we(mem_we), .lmd_we(lmd_we),
    .dst_from_rd(dst_from_rd), .b_from_imm(b_from_imm),
    .wb_from_mem(wb_from_mem), .imm_signed(imm_signed),
    .alu_op(alu_op), .state_code(state_code)
  );

  function automatic logic [18:0] actual();
    return {state_code, pc_we, npc_we, ir_we, rf_we, aluout_we, mem_we, lmd_we,
            dst_from_rd, b_from_imm, wb_from_mem, imm_signed, alu_op};
  endfunction

  // expected pattern per state, from the requirement list
  function automatic logic [18:0] expect_of(input logic [3:0] s, input logic [2:0] fn);
    logic pc = 0, npc = 0, ir = 0, rf = 0, ao = 0, mw = 0, lm = 0;
    logic dr = 0, bi = 0, wm = 0, sx = 0;
    logic [3:0] af = 4'd0;
    case (s)
      4'd0: begin ir = 1; npc = 1; end                                   // R1
      4'd2: begin ao = 1; af = (fn == 3'b001) ? 4'b0100 :
                              (fn == 3'b011) ? 4'b0010 : 4'b0000; end     // R4
      4'd3: begin rf = 1; dr = 1; pc = 1; end                            // R4
      4'd4: begin sx = 1; bi = 1; ao = 1; af = 4'b0100; end              // R5
      4'd5: lm = 1;                                                      // R6
      4'd6: begin rf = 1; wm = 1; pc = 1; end                            // R6
      4'd7: begin mw = 1; pc = 1; end                                    // R7
      4'd8: begin bi = 1; ao = 1; af = 4'b0001; end                      // R8
      4'd9: begin rf = 1; pc = 1; end                                    // R8
      default: ;                                                         // R2 R10
    endcase
    return {s, pc, npc, ir, rf, ao, mw, lm, dr, bi, wm, sx, af};
  endfunction

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] s, input logic [2:0] fn, input string tag);
    exp_q.push_back(expect_of(s, fn));
    tag_q.push_back(tag);
  endtask

  // driver: called at a falling edge with the design in fetch
  task automatic instr(input logic [3:0] op, input logic [2:0] fn, input string tag);
    opcode = op;
    func   = fn;
    push(4'd1, fn, {tag, " R2 decode"});
    case (op)
      4'b0000: begin push(4'd2, fn, {tag, " R4"}); push(4'd3, fn, {tag, " R4"}); end
      4'b0001: begin push(4'd4, fn, {tag, " R5"}); push(4'd5, fn, {tag, " R6"});
                     push(4'd6, fn, {tag, " R6"}); end
      4'b0010: begin push(4'd4, fn, {tag, " R5"}); push(4'd7, fn, {tag, " R7"}); end
      4'b0100: begin push(4'd8, fn, {tag, " R8"}); push(4'd9, fn, {tag, " R8"}); end
      default: ;
    endcase
    push(4'd0, fn, {tag, " R9 return R3"});
    do @(negedge clk); while (exp_q.size() != 0);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() != 0) check(tag_q.pop_front(), actual(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", actual(), expect_of(4'd0, 3'd0));
    rst = 1'b0;
    instr(4'b0000, 3'b001, "add");
    instr(4'b0000, 3'b011, "and");
    instr(4'b0000, 3'b101, "rtype other func");
    instr(4'b0001, 3'b000, "load");
    instr(4'b0010, 3'b111, "store");
    instr(4'b0100, 3'b010, "ori");
    instr(4'b0011, 3'b001, "undefined 0011");
    instr(4'b1111, 3'b011, "undefined 1111");
    instr(4'b0001, 3'b011, "load again");
    // reset in the middle of an R-type sequence
    opcode = 4'b0000; func = 3'b001;
    @(negedge clk); @(negedge clk);
    check("R4 mid state before reset", actual(), expect_of(4'd2, 3'b001));
    rst = 1'b1;
    @(posedge clk); #5;
    check("R1 reset mid instruction", actual(), expect_of(4'd0, 3'b001));
    @(negedge clk);
    rst = 1'b0;
    instr(4'b0100, 3'b000, "ori after reset");
    instr(4'b0010, 3'b001, "store after reset");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule